// File: doc/BRIEF.md
# Memory Strobe Timing Generator with Slow-Clock Override

This block runs one access at a time on an external static memory bus. A request carries a direction, a chip-select index, an address and byte enables. Once accepted, the block counts clocks from the first cycle of the access and drives an active-low chip select for the chosen device, plus an active-low read or write strobe. The address and byte enables it captured stay on the bus until the access ends, and a one-clock done pulse marks the last cycle.

Each strobe and the chip select have a programmed start offset (setup) and width (pulse). The access lasts for a programmed total count, but never ends before the strobe or chip-select window has closed. When the bus clock has been slowed down, a slow-mode flag swaps every programmed value for a fixed built-in set. This applies to every chip select, so software does not have to rewrite the timing registers after a clock change. The flag is read only when an access is accepted.

Top module: `strobe_timing_gen`

## Requirements
- R1: Out of reset and whenever idle, all chip selects and both strobes are high (inactive), done is low and req_ready is high.
- R2: In a normal-mode read, the read strobe is low in access cycles t with rd_setup <= t < rd_setup+rd_pulse. Chip select number req_cs (binary index) is low for rd_cs_setup <= t < rd_cs_setup+rd_cs_pulse. The other chip selects and the write strobe stay high. Cycle t=0 is the first output cycle after the accepting clock edge.
- R3: A normal-mode write does the same with the wr_* values and the write strobe, and the read strobe stays high.
- R4: An access lasts max(cycle count, setup+pulse, cs setup+cs pulse, 1) cycles.
- R5: A pulse count of 0 means that strobe or chip select is never asserted during the access.
- R6: In slow mode a read has strobe setup 1 and pulse 1, chip-select setup 0 and pulse 2, and a length of 2, whatever the registers hold.
- R7: In slow mode a write has strobe setup 1 and pulse 1, chip-select setup 0 and pulse 3, and a length of 3, whatever the registers hold.
- R8: The slow-mode timing applies to every chip-select index.
- R9: slow_mode is sampled only at acceptance. Changing it during an access leaves that access's waveform unchanged.
- R10: bus_addr and bus_be hold the values captured at acceptance for every cycle of the access, even if the request inputs change.
- R11: done is high for exactly the last cycle of an access. req_ready is low throughout the access, and a request held high during an access is not accepted until the cycle after done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_cs | input | CS_IDX_W | Chip-select index |
| req_addr | input | ADDR_W | Access address |
| req_be | input | BE_W | Byte enables |
| slow_mode | input | 1 | Use built-in slow timing |
| rd_setup | input | CNT_W | Read strobe setup |
| rd_pulse | input | CNT_W | Read strobe width |
| rd_cs_setup | input | CNT_W | Chip-select setup for reads |
| rd_cs_pulse | input | CNT_W | Chip-select width for reads |
| rd_cycle | input | CNT_W | Read access length |
| wr_setup | input | CNT_W | Write strobe setup |
| wr_pulse | input | CNT_W | Write strobe width |
| wr_cs_setup | input | CNT_W | Chip-select setup for writes |
| wr_cs_pulse | input | CNT_W | Chip-select width for writes |
| wr_cycle | input | CNT_W | Write access length |
| req_ready | output | 1 | Idle, request may be accepted |
| bus_addr | output | ADDR_W | Held address |
| bus_be | output | BE_W | Held byte enables |
| bus_cs_n | output | NUM_CS | Active-low chip selects |
| bus_rd_n | output | 1 | Active-low read strobe |
| bus_wr_n | output | 1 | Active-low write strobe |
| done | output | 1 | Last cycle of access |

## Verification
Two events can land in the same cycle as the end of an access, and both are provoked on purpose. The first is a request held high while the done pulse is showing. The bench keeps req_valid asserted, with a different chip select and address, through the whole access. It then checks that nothing starts early, that the captured address does not move, and that the bus is idle right after done. The second is a slow_mode change in the cycle right after acceptance, in both directions. The bench judges each cycle against the timing set chosen when the access was accepted.

// File: rtl/stg_pkg.sv
package stg_pkg;
  // built-in timing used while the bus clock is slowed down
  localparam int SLOW_RD_SETUP    = 1;
  localparam int SLOW_RD_PULSE    = 1;
  localparam int SLOW_RD_CS_SETUP = 0;
  localparam int SLOW_RD_CS_PULSE = 2;
  localparam int SLOW_RD_CYCLE    = 2;
  localparam int SLOW_WR_SETUP    = 1;
  localparam int SLOW_WR_PULSE    = 1;
  localparam int SLOW_WR_CS_SETUP = 0;
  localparam int SLOW_WR_CS_PULSE = 3;
  localparam int SLOW_WR_CYCLE    = 3;

  typedef enum logic [0:0] {ST_IDLE = 1'b0, ST_RUN = 1'b1} stg_state_e;
endpackage

// File: rtl/stg_timing_sel.sv
module stg_timing_sel
  import stg_pkg::*;
#(
  parameter int CNT_W = 6,
  parameter int LEN_W = CNT_W + 2
) (
  input  logic             is_write,
  input  logic             slow,
  input  logic [CNT_W-1:0] rd_setup,
  input  logic [CNT_W-1:0] rd_pulse,
  input  logic [CNT_W-1:0] rd_cs_setup,
  input  logic [CNT_W-1:0] rd_cs_pulse,
  input  logic [CNT_W-1:0] rd_cycle,
  input  logic [CNT_W-1:0] wr_setup,
  input  logic [CNT_W-1:0] wr_pulse,
  input  logic [CNT_W-1:0] wr_cs_setup,
  input  logic [CNT_W-1:0] wr_cs_pulse,
  input  logic [CNT_W-1:0] wr_cycle,
  output logic [CNT_W-1:0] sel_setup,
  output logic [CNT_W-1:0] sel_pulse,
  output logic [CNT_W-1:0] sel_cs_setup,
  output logic [CNT_W-1:0] sel_cs_pulse,
  output logic [LEN_W-1:0] sel_len
);
  logic [CNT_W-1:0] cyc;
  logic [LEN_W-1:0] strobe_end, cs_end, longest;

  always_comb begin
    unique case ({slow, is_write})
      2'b00: begin
        sel_setup = rd_setup;  sel_pulse = rd_pulse;
        sel_cs_setup = rd_cs_setup; sel_cs_pulse = rd_cs_pulse; cyc = rd_cycle;
      end
      2'b01: begin
        sel_setup = wr_setup;  sel_pulse = wr_pulse;
        sel_cs_setup = wr_cs_setup; sel_cs_pulse = wr_cs_pulse; cyc = wr_cycle;
      end
      2'b10: begin
        sel_setup    = CNT_W'(SLOW_RD_SETUP);
        sel_pulse    = CNT_W'(SLOW_RD_PULSE);
        sel_cs_setup = CNT_W'(SLOW_RD_CS_SETUP);
        sel_cs_pulse = CNT_W'(SLOW_RD_CS_PULSE);
        cyc          = CNT_W'(SLOW_RD_CYCLE);
      end
      default: begin
        sel_setup    = CNT_W'(SLOW_WR_SETUP);
        sel_pulse    = CNT_W'(SLOW_WR_PULSE);
        sel_cs_setup = CNT_W'(SLOW_WR_CS_SETUP);
        sel_cs_pulse = CNT_W'(SLOW_WR_CS_PULSE);
        cyc          = CNT_W'(SLOW_WR_CYCLE);
      end
    endcase
  end

  // length never shorter than either window, and at least one cycle (R4)
  always_comb begin
    strobe_end = LEN_W'(sel_setup) + LEN_W'(sel_pulse);
    cs_end     = LEN_W'(sel_cs_setup) + LEN_W'(sel_cs_pulse);
    longest    = LEN_W'(cyc);
    if (strobe_end > longest) longest = strobe_end;
    if (cs_end > longest)     longest = cs_end;
    sel_len = (longest == '0) ? LEN_W'(1) : longest;
  end
endmodule

// File: rtl/stg_window.sv
module stg_window #(
  parameter int CNT_W = 6,
  parameter int LEN_W = CNT_W + 2
) (
  input  logic [LEN_W-1:0] t,
  input  logic [CNT_W-1:0] start,
  input  logic [CNT_W-1:0] width,
  output logic             on
);
  logic [LEN_W-1:0] stop;
  always_comb begin
    stop = LEN_W'(start) + LEN_W'(width);
    on   = (t >= LEN_W'(start)) && (t < stop);
  end
endmodule

// File: rtl/strobe_timing_gen.sv
module strobe_timing_gen
  import stg_pkg::*;
#(
  parameter int NUM_CS   = 4,
  parameter int ADDR_W   = 24,
  parameter int BE_W     = 2,
  parameter int CNT_W    = 6,
  parameter int CS_IDX_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic [CS_IDX_W-1:0] req_cs,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [BE_W-1:0]     req_be,
  input  logic                slow_mode,
  input  logic [CNT_W-1:0]    rd_setup,
  input  logic [CNT_W-1:0]    rd_pulse,
  input  logic [CNT_W-1:0]    rd_cs_setup,
  input  logic [CNT_W-1:0]    rd_cs_pulse,
  input  logic [CNT_W-1:0]    rd_cycle,
  input  logic [CNT_W-1:0]    wr_setup,
  input  logic [CNT_W-1:0]    wr_pulse,
  input  logic [CNT_W-1:0]    wr_cs_setup,
  input  logic [CNT_W-1:0]    wr_cs_pulse,
  input  logic [CNT_W-1:0]    wr_cycle,
  output logic                req_ready,
  output logic [ADDR_W-1:0]   bus_addr,
  output logic [BE_W-1:0]     bus_be,
  output logic [NUM_CS-1:0]   bus_cs_n,
  output logic                bus_rd_n,
  output logic                bus_wr_n,
  output logic                done
);
  localparam int LEN_W = CNT_W + 2;

  stg_state_e          state_q;
  logic [LEN_W-1:0]    t_q, t_nxt, len_q, len_mux;
  logic                wr_q, slow_q, wr_mux;
  logic [CS_IDX_W-1:0] cs_q, cs_mux;
  logic [CNT_W-1:0]    setup_q, pulse_q, cs_setup_q, cs_pulse_q;
  logic [CNT_W-1:0]    setup_mux, pulse_mux, cs_setup_mux, cs_pulse_mux;
  logic [CNT_W-1:0]    n_setup, n_pulse, n_cs_setup, n_cs_pulse;
  logic [LEN_W-1:0]    n_len;
  logic                accept, strobe_on, cs_on, last_nxt;
  logic [NUM_CS-1:0]   cs_n_nxt;

  assign accept    = (state_q == ST_IDLE) && req_valid;
  assign req_ready = (state_q == ST_IDLE);

  stg_timing_sel #(.CNT_W(CNT_W), .LEN_W(LEN_W)) u_sel (
    .is_write(req_write), .slow(slow_mode),
    .rd_setup(rd_setup), .rd_pulse(rd_pulse), .rd_cs_setup(rd_cs_setup),
    .rd_cs_pulse(rd_cs_pulse), .rd_cycle(rd_cycle),
    .wr_setup(wr_setup), .wr_pulse(wr_pulse), .wr_cs_setup(wr_cs_setup),
    .wr_cs_pulse(wr_cs_pulse), .wr_cycle(wr_cycle),
    .sel_setup(n_setup), .sel_pulse(n_pulse), .sel_cs_setup(n_cs_setup),
    .sel_cs_pulse(n_cs_pulse), .sel_len(n_len)
  );

  // timing for the next output cycle: fresh on accept, latched otherwise
  always_comb begin
    if (accept) begin
      t_nxt = '0;
      setup_mux = n_setup; pulse_mux = n_pulse;
      cs_setup_mux = n_cs_setup; cs_pulse_mux = n_cs_pulse;
      len_mux = n_len; wr_mux = req_write; cs_mux = req_cs;
    end else begin
      t_nxt = t_q + LEN_W'(1);
      setup_mux = setup_q; pulse_mux = pulse_q;
      cs_setup_mux = cs_setup_q; cs_pulse_mux = cs_pulse_q;
      len_mux = len_q; wr_mux = wr_q; cs_mux = cs_q;
    end
    last_nxt = (t_nxt == len_mux - LEN_W'(1));
  end

  stg_window #(.CNT_W(CNT_W), .LEN_W(LEN_W)) u_strobe_win (
    .t(t_nxt), .start(setup_mux), .width(pulse_mux), .on(strobe_on)
  );
  stg_window #(.CNT_W(CNT_W), .LEN_W(LEN_W)) u_cs_win (
    .t(t_nxt), .start(cs_setup_mux), .width(cs_pulse_mux), .on(cs_on)
  );

  for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
    assign cs_n_nxt[i] = !(cs_on && (cs_mux == CS_IDX_W'(i)));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      t_q <= '0; len_q <= LEN_W'(1);
      wr_q <= 1'b0; slow_q <= 1'b0; cs_q <= '0;
      setup_q <= '0; pulse_q <= '0; cs_setup_q <= '0; cs_pulse_q <= '0;
      bus_addr <= '0; bus_be <= '0;
      bus_cs_n <= '1; bus_rd_n <= 1'b1; bus_wr_n <= 1'b1; done <= 1'b0;
    end else if (accept) begin
      state_q <= ST_RUN;
      t_q <= t_nxt; len_q <= n_len;
      wr_q <= req_write; slow_q <= slow_mode; cs_q <= req_cs;
      setup_q <= n_setup; pulse_q <= n_pulse;
      cs_setup_q <= n_cs_setup; cs_pulse_q <= n_cs_pulse;
      bus_addr <= req_addr; bus_be <= req_be;
      bus_cs_n <= cs_n_nxt;
      bus_rd_n <= !(strobe_on && !wr_mux);
      bus_wr_n <= !(strobe_on && wr_mux);
      done <= last_nxt;
    end else if (state_q == ST_RUN) begin
      if (done) begin
        state_q <= ST_IDLE;
        bus_cs_n <= '1; bus_rd_n <= 1'b1; bus_wr_n <= 1'b1; done <= 1'b0;
      end else begin
        t_q <= t_nxt;
        bus_cs_n <= cs_n_nxt;
        bus_rd_n <= !(strobe_on && !wr_mux);
        bus_wr_n <= !(strobe_on && wr_mux);
        done <= last_nxt;
      end
    end
  end

  // checks on the bus behaviour
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (bus_cs_n == '1) && bus_rd_n && bus_wr_n && !done); // R1
  AST_ONE_CS: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~bus_cs_n)); // R2
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
    !(!bus_rd_n && !bus_wr_n)); // R3
  AST_SLOW_RD_END: assert property (@(posedge clk) disable iff (rst)
    (!req_ready && slow_q && !wr_q && t_q == LEN_W'(1)) |-> done); // R6
  AST_SLOW_WR_END: assert property (@(posedge clk) disable iff (rst)
    (!req_ready && slow_q && wr_q && t_q == LEN_W'(2)) |-> done); // R7
  AST_SLOW_FIRST_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!req_ready && slow_q && t_q == '0) |-> (bus_rd_n && bus_wr_n && bus_cs_n != '1)); // R8
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
    (!req_ready && !done) |=> ($stable(bus_addr) && $stable(bus_be))); // R10
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R11
  AST_DONE_BUSY: assert property (@(posedge clk) disable iff (rst)
    done |-> !req_ready); // R11
endmodule

// File: tb/strobe_timing_gen_tb.sv
module strobe_timing_gen_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_CS = 4, ADDR_W = 24, BE_W = 2, CNT_W = 6, CS_IDX_W = 2;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0, slow_mode = 1'b0;
  logic [CS_IDX_W-1:0] req_cs = '0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [BE_W-1:0] req_be = '0;
  logic [CNT_W-1:0] rd_setup = '0, rd_pulse = '0, rd_cs_setup = '0, rd_cs_pulse = '0, rd_cycle = '0;
  logic [CNT_W-1:0] wr_setup = '0, wr_pulse = '0, wr_cs_setup = '0, wr_cs_pulse = '0, wr_cycle = '0;
  logic req_ready, bus_rd_n, bus_wr_n, done;
  logic [ADDR_W-1:0] bus_addr;
  logic [BE_W-1:0] bus_be;
  logic [NUM_CS-1:0] bus_cs_n;

  int checks = 0, fails = 0, cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  strobe_timing_gen #(.NUM_CS(NUM_CS), .ADDR_W(ADDR_W), .BE_W(BE_W), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write), .req_cs(req_cs),
    .req_addr(req_addr), .req_be(req_be), .slow_mode(slow_mode),
    .rd_setup(rd_setup), .rd_pulse(rd_pulse), .rd_cs_setup(rd_cs_setup),
    .rd_cs_pulse(rd_cs_pulse), .rd_cycle(rd_cycle),
    .wr_setup(wr_setup), .wr_pulse(wr_pulse), .wr_cs_setup(wr_cs_setup),
    .wr_cs_pulse(wr_cs_pulse), .wr_cycle(wr_cycle),
    .req_ready(req_ready), .bus_addr(bus_addr), .bus_be(bus_be), .bus_cs_n(bus_cs_n),
    .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n), .done(done)
  );

  task automatic check(input logic ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++; checks++;
      $display("FAIL watchdog: actual %0d expected below 100000 cycles", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic check_idle(input string req);
    check(bus_cs_n == '1, req, "idle cs_n", bus_cs_n, 4'hf);
    check(bus_rd_n && bus_wr_n, req, "idle strobes", {bus_rd_n, bus_wr_n}, 2'b11);
    check(!done, req, "idle done", done, 0);
    check(req_ready, req, "idle ready", req_ready, 1);
  endtask

  // one access; expected waveform from the requirement timing
  task automatic run_access(input logic wr, input int cs, input logic sl,
                            input logic toggle_slow, input logic hold_req, input string req);
    int s, p, cst, csp, cyc, len;
    logic [ADDR_W-1:0] a;
    logic [BE_W-1:0] b;
    a = ADDR_W'(32'h5A0000 + cs * 32'h111 + (wr ? 7 : 3));
    b = BE_W'(cs + 1);
    if (sl) begin
      s = 1; p = 1; cst = 0;
      csp = wr ? 3 : 2; cyc = wr ? 3 : 2;
    end else if (wr) begin
      s = wr_setup; p = wr_pulse; cst = wr_cs_setup; csp = wr_cs_pulse; cyc = wr_cycle;
    end else begin
      s = rd_setup; p = rd_pulse; cst = rd_cs_setup; csp = rd_cs_pulse; cyc = rd_cycle;
    end
    len = cyc;
    if (s + p > len) len = s + p;
    if (cst + csp > len) len = cst + csp;
    if (len == 0) len = 1;

    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_cs = CS_IDX_W'(cs);
    req_addr = a; req_be = b; slow_mode = sl;
    @(negedge clk);
    for (int t = 0; t < len; t++) begin
      logic st, co;
      logic [NUM_CS-1:0] exp_cs;
      st = (t >= s) && (t < s + p);
      co = (t >= cst) && (t < cst + csp);
      exp_cs = '1;
      if (co) exp_cs[cs] = 1'b0;
      check(bus_cs_n == exp_cs, req, $sformatf("cs_n t=%0d", t), bus_cs_n, exp_cs);
      check(bus_rd_n == !(st && !wr), req, $sformatf("rd_n t=%0d", t), bus_rd_n, !(st && !wr));
      check(bus_wr_n == !(st && wr), req, $sformatf("wr_n t=%0d", t), bus_wr_n, !(st && wr));
      check(bus_addr == a && bus_be == b, "R10", $sformatf("addr/be t=%0d", t),
            {bus_addr, bus_be}, {a, b});
      check(done == (t == len - 1), "R11", $sformatf("done t=%0d", t), done, (t == len - 1));
      check(!req_ready, "R11", $sformatf("ready t=%0d", t), req_ready, 0);
      if (t == 0) begin
        req_addr = ~a; req_be = ~b;
        req_cs = CS_IDX_W'(cs + 1);
        if (toggle_slow) slow_mode = ~sl;
        if (!hold_req) req_valid = 1'b0;
      end
      if (t == len - 1) req_valid = 1'b0;
      @(negedge clk);
    end
    check_idle(req);
    slow_mode = 1'b0;
  endtask

  task automatic test_reset();
    check_idle("R1");
  endtask

  task automatic test_prog_read();
    rd_setup = 2; rd_pulse = 3; rd_cs_setup = 1; rd_cs_pulse = 5; rd_cycle = 4;
    run_access(1'b0, 1, 1'b0, 1'b0, 1'b0, "R2"); // R4 length 6 from chip-select window
  endtask

  task automatic test_prog_write();
    wr_setup = 0; wr_pulse = 2; wr_cs_setup = 0; wr_cs_pulse = 2; wr_cycle = 7;
    run_access(1'b1, 3, 1'b0, 1'b0, 1'b0, "R3"); // R4 length from cycle count
  endtask

  task automatic test_zero_pulse();
    rd_setup = 1; rd_pulse = 0; rd_cs_setup = 0; rd_cs_pulse = 0; rd_cycle = 3;
    run_access(1'b0, 0, 1'b0, 1'b0, 1'b0, "R5");
    rd_setup = 0; rd_pulse = 0; rd_cs_setup = 0; rd_cs_pulse = 0; rd_cycle = 0;
    run_access(1'b0, 2, 1'b0, 1'b0, 1'b0, "R4"); // minimum length 1
  endtask

  task automatic test_slow_read();
    rd_setup = 9; rd_pulse = 7; rd_cs_setup = 4; rd_cs_pulse = 12; rd_cycle = 30;
    run_access(1'b0, 2, 1'b1, 1'b0, 1'b0, "R6");
    run_access(1'b0, 0, 1'b1, 1'b0, 1'b0, "R8");
  endtask

  task automatic test_slow_write();
    wr_setup = 5; wr_pulse = 5; wr_cs_setup = 2; wr_cs_pulse = 20; wr_cycle = 40;
    run_access(1'b1, 3, 1'b1, 1'b0, 1'b0, "R7");
    run_access(1'b1, 1, 1'b1, 1'b0, 1'b0, "R8");
  endtask

  task automatic test_slow_toggle();
    rd_setup = 2; rd_pulse = 2; rd_cs_setup = 1; rd_cs_pulse = 4; rd_cycle = 6;
    run_access(1'b0, 1, 1'b0, 1'b1, 1'b0, "R9"); // slow raised mid access
    run_access(1'b1, 2, 1'b1, 1'b1, 1'b0, "R9"); // slow dropped mid access
  endtask

  task automatic test_held_request();
    wr_setup = 1; wr_pulse = 2; wr_cs_setup = 0; wr_cs_pulse = 4; wr_cycle = 4;
    run_access(1'b1, 0, 1'b0, 1'b0, 1'b1, "R11");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    test_reset();
    test_prog_read();
    test_prog_write();
    test_zero_pulse();
    test_slow_read();
    test_slow_write();
    test_slow_toggle();
    test_held_request();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule